// File: doc/BRIEF.md
# Reconfiguration Trigger CSR Responder

This block is the engine side of a profile-switch handshake. A host programs a bank of profile words over a simple register port and then sets a trigger bit. The engine accepts the trigger and copies the profile bank into a private shadow. It then replays the shadow as a fixed series of register writes to four downstream sub-blocks: the MAC, then the PCS, then the FEC, then the PMA.

The host sees only a one-bit trigger and a one-bit ready flag. It polls ready until it reads 1. It then writes the profile and sets the trigger. It polls ready again to learn that every downstream write has landed.

The profile bank holds NUM_PROF words, 20 by default. The words are split evenly across the four sub-blocks. Word `b*PER_BLK + k` becomes write `k` to sub-block `b`, where PER_BLK is NUM_PROF/4.

Top module: `recfg_csr_responder`

## Requirements
- R1: After reset, the control word reads 0x2: ready = 1, trigger = 0, overrun = 0. Every profile word reads 0.
- R2: Profile word i (i = 0 .. NUM_PROF-1) sits at byte address 4*(i+1), so 0x04 .. 0x50 by default. It reads back what was written. A word-aligned address outside 0x00 .. 0x50 reads 0, and a write to it changes nothing.
- R3: Control word bit 0 is the trigger, bit 1 is ready and bit 2 is overrun. Writing 1 to bit 0 while ready = 1 makes the control word read 0x3 in the following cycle. On the next edge the trigger is accepted: bit 0 self-clears and ready drops, so the word reads 0x0.
- R4: An accepted trigger produces exactly NUM_PROF downstream writes, issued in port order MAC (dn_valid bit 0), PCS (bit 1), FEC (bit 2), PMA (bit 3). Write k to port b carries dn_addr = k and dn_data = profile word b*PER_BLK + k.
- R5: At most one dn_valid bit is high at any time. Once a write is presented, dn_valid, dn_addr and dn_data hold steady until the selected port's dn_ready is high. A write completes only in a cycle where both are high.
- R6: Ready returns to 1 only after the final PMA write has completed. It reads 1 from the cycle after that handshake.
- R7: A trigger written while ready = 0 is ignored and adds no downstream writes. It sets overrun (bit 2), which then reads 1.
- R8: Overrun is write-1-to-clear. Writing 0 to bit 2 leaves it set.
- R9: The profile is captured when the trigger is accepted. Profile writes made during a switch do not change that switch's writes. They are stored and used by the next switch.
- R10: While the selected port holds dn_ready low the engine stalls with no progress. dn_ready bits of unselected ports have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | 8 | Host byte address (word aligned) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr (combinational) |
| dn_valid | output | 4 | One-hot write request: bit0 MAC, bit1 PCS, bit2 FEC, bit3 PMA |
| dn_ready | input | 4 | Per-port write acknowledge |
| dn_addr | output | 4 | Sub-block register index of the current write |
| dn_data | output | 32 | Data of the current write |

## Verification
The bench triggers a switch and then, mid-switch, rewrites a profile word and writes the trigger again. A design without a snapshot would leak the new word into the running sequence. A design that did not gate the trigger on ready would start a second, overlapping sequence or miss the overrun flag.

Acknowledges are driven pseudo-randomly on all four ports, including ports that are not selected. This exposes a design that advances on a stray acknowledge or that changes data before a handshake. A long full stall checks that nothing moves while no acknowledge arrives.

Ready is polled against the count of completed writes, which catches a ready flag that rises one write early.

// File: rtl/recfg_pkg.sv
package recfg_pkg;
  localparam int NUM_BLK = 4;

  typedef enum logic [1:0] {
    BLK_MAC = 2'd0,
    BLK_PCS = 2'd1,
    BLK_FEC = 2'd2,
    BLK_PMA = 2'd3
  } blk_e;

  localparam int CTRL_TRIG_BIT  = 0;
  localparam int CTRL_READY_BIT = 1;
  localparam int CTRL_OVR_BIT   = 2;
endpackage

// File: rtl/recfg_csr_bank.sv
module recfg_csr_bank
  import recfg_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter int NUM_PROF = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output logic                   start,
  input  logic                   done,
  output logic [NUM_PROF*DW-1:0] prof_flat
);
  localparam int WIDX_W = AW - 2;

  logic [DW-1:0]     prof_q [NUM_PROF];
  logic              trig_q, ready_q, ovr_q;
  logic [WIDX_W-1:0] widx;
  logic              aligned, ctrl_hit;

  assign widx     = addr[AW-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign ctrl_hit = aligned && (widx == '0);
  assign start    = trig_q && ready_q;

  logic ctrl_wr, trig_req, ovr_clr;
  assign ctrl_wr  = wr_en && ctrl_hit;
  assign trig_req = ctrl_wr && wdata[CTRL_TRIG_BIT];
  assign ovr_clr  = ctrl_wr && wdata[CTRL_OVR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q  <= 1'b0;
      ready_q <= 1'b1;
      ovr_q   <= 1'b0;
    end else begin
      if (start) begin
        trig_q  <= 1'b0;
        ready_q <= 1'b0;
      end else if (trig_req && ready_q) begin
        trig_q <= 1'b1;
      end
      if (done) ready_q <= 1'b1;
      if (trig_req && !ready_q) ovr_q <= 1'b1;
      else if (ovr_clr)         ovr_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_PROF; i++) begin : g_prof
    localparam logic [WIDX_W-1:0] MY_IDX = WIDX_W'(i + 1);
    always_ff @(posedge clk) begin
      if (!rst_n)                                   prof_q[i] <= '0;
      else if (wr_en && aligned && widx == MY_IDX)  prof_q[i] <= wdata;
    end
    assign prof_flat[i*DW +: DW] = prof_q[i];
  end

  always_comb begin
    rdata = '0;
    if (ctrl_hit) begin
      rdata[CTRL_TRIG_BIT]  = trig_q;
      rdata[CTRL_READY_BIT] = ready_q;
      rdata[CTRL_OVR_BIT]   = ovr_q;
    end else if (aligned) begin
      for (int i = 0; i < NUM_PROF; i++)
        if (widx == WIDX_W'(i + 1)) rdata = prof_q[i];
    end
  end

  // Accepting a trigger must drop ready on the following cycle.
  assert_ready_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready_q);
  // Ready may only rise after the engine reports the last handshake.
  assert_ready_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_q && !done) |=> !ready_q);
  // A trigger arriving while busy must leave overrun set.
  assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_req && !ready_q) |=> (ovr_q && !trig_q));
endmodule

// File: rtl/recfg_seq_engine.sv
module recfg_seq_engine
  import recfg_pkg::*;
#(
  parameter int DW       = 32,
  parameter int NUM_PROF = 20,
  parameter int BLK_AW   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [NUM_PROF*DW-1:0] prof_flat,
  output logic                   done,
  output logic [NUM_BLK-1:0]     dn_valid,
  input  logic [NUM_BLK-1:0]     dn_ready,
  output logic [BLK_AW-1:0]      dn_addr,
  output logic [DW-1:0]          dn_data
);
  localparam int PER_BLK = NUM_PROF / NUM_BLK;
  localparam int KW      = (PER_BLK > 1) ? $clog2(PER_BLK) : 1;
  localparam int IW      = (NUM_PROF > 1) ? $clog2(NUM_PROF) : 1;
  localparam logic [KW-1:0] K_LAST = KW'(PER_BLK - 1);

  logic [DW-1:0] shadow_q [NUM_PROF];
  logic          busy_q;
  blk_e          blk_q;
  logic [KW-1:0] k_q;
  logic [IW-1:0] sel_idx;
  logic          hs, last_k;

  assign sel_idx = IW'(32'(blk_q) * PER_BLK + 32'(k_q));
  assign hs      = busy_q && dn_ready[blk_q];
  assign last_k  = (k_q == K_LAST);
  assign done    = hs && last_k && (blk_q == BLK_PMA);
  assign dn_addr = BLK_AW'(k_q);
  assign dn_data = shadow_q[sel_idx];

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_valid
    assign dn_valid[b] = busy_q && (blk_q == blk_e'(b));
  end

  for (genvar i = 0; i < NUM_PROF; i++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (!rst_n)     shadow_q[i] <= '0;
      else if (start) shadow_q[i] <= prof_flat[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      blk_q  <= BLK_MAC;
      k_q    <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      blk_q  <= BLK_MAC;
      k_q    <= '0;
    end else if (hs) begin
      if (last_k) begin
        k_q <= '0;
        if (blk_q == BLK_PMA) busy_q <= 1'b0;
        else                  blk_q  <= blk_e'(blk_q + 2'd1);
      end else begin
        k_q <= k_q + KW'(1);
      end
    end
  end

  assert_one_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_valid));
  assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !dn_ready[blk_q]) |=> ($stable(dn_valid) && $stable(dn_addr) && $stable(dn_data)));
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start);
endmodule

// File: rtl/recfg_csr_responder.sv
module recfg_csr_responder
  import recfg_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter int NUM_PROF = 20,
  parameter int BLK_AW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [AW-1:0]     host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic [NUM_BLK-1:0] dn_valid,
  input  logic [NUM_BLK-1:0] dn_ready,
  output logic [BLK_AW-1:0] dn_addr,
  output logic [DW-1:0]     dn_data
);
  logic                   start, done;
  logic [NUM_PROF*DW-1:0] prof_flat;

  recfg_csr_bank #(.DW(DW), .AW(AW), .NUM_PROF(NUM_PROF)) csr_i (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr_en), .addr(host_addr),
    .wdata(host_wdata), .rdata(host_rdata), .start(start), .done(done),
    .prof_flat(prof_flat)
  );

  recfg_seq_engine #(.DW(DW), .NUM_PROF(NUM_PROF), .BLK_AW(BLK_AW)) eng_i (
    .clk(clk), .rst_n(rst_n), .start(start), .prof_flat(prof_flat),
    .done(done), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_addr(dn_addr), .dn_data(dn_data)
  );
endmodule

// File: tb/recfg_csr_responder_tb.sv
module recfg_csr_responder_tb_top;
  localparam int NP  = 20;
  localparam int PB  = NP / 4;
  localparam int WDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [3:0]  dn_valid;
  logic [3:0]  dn_ready = '0;
  logic [3:0]  dn_addr;
  logic [31:0] dn_data;

  always #4 clk = ~clk;

  recfg_csr_responder dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .dn_valid(dn_valid),
    .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_data(dn_data)
  );

  int errors = 0;
  int checks = 0;
  int hs_count = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] model [NP];

  typedef struct packed { logic [1:0] port; logic [3:0] addr; logic [31:0] data; } wr_t;
  wr_t expq [$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic push_expected();
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < PB; k++)
        expq.push_back('{port: 2'(b), addr: 4'(k), data: model[b*PB + k]});
    hs_count = 0;
  endtask

  task automatic wait_ready();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      hread(8'h00, v);
      if (v[1]) begin
        chk("R6 writes done when ready rises", 32'(hs_count), 32'(NP));
        return;
      end
    end
    chk("R6 ready never returned", 32'd0, 32'd1);
  endtask

  // Monitor and acknowledge driver
  always @(negedge clk) begin
    if (rdy_mode == 0)      dn_ready = 4'hF;
    else if (rdy_mode == 2) dn_ready = 4'h0;
    else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      dn_ready = lfsr[3:0];
    end
    if (rst_n) begin
      if ($countones(dn_valid) > 1) chk("R5 one valid port", 32'(dn_valid), 32'd0);
      for (int b = 0; b < 4; b++) begin
        if (dn_valid[b] && dn_ready[b]) begin
          wr_t e;
          hs_count++;
          if (expq.size() == 0) chk("R7 unexpected extra write", {28'd0, dn_addr}, 32'hFFFF_FFFF);
          else begin
            e = expq.pop_front();
            chk("R4 port order", 32'(b), 32'(e.port));
            chk("R4 write addr", 32'(dn_addr), 32'(e.addr));
            chk("R4 R9 write data", dn_data, e.data);
          end
        end
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG) begin
      errors++; checks++;
      $display("FAIL R4 watchdog expired actual=%0d expected<%0d", cyc, WDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [3:0]  sv_valid, sv_addr;
    logic [31:0] sv_data;
    int          sv_cnt;
    for (int i = 0; i < NP; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    hread(8'h00, v); chk("R1 ctrl reset", v, 32'h2);
    hread(8'h04, v); chk("R1 prof0 reset", v, 32'h0);
    hread(8'h50, v); chk("R1 prof19 reset", v, 32'h0);

    for (int i = 0; i < NP; i++) begin
      model[i] = 32'hA500_0000 | (32'(i) << 8) | 32'(i * 3 + 1);
      hwrite(8'(4 * (i + 1)), model[i]);
    end
    hread(8'h04, v); chk("R2 prof0 readback", v, model[0]);
    hread(8'h2C, v); chk("R2 prof10 readback", v, model[10]);
    hread(8'h50, v); chk("R2 prof19 readback", v, model[19]);
    hwrite(8'h54, 32'hDEAD_BEEF);
    hread(8'h54, v); chk("R2 unmapped reads 0", v, 32'h0);
    hread(8'h50, v); chk("R2 unmapped write no effect", v, model[19]);

    // Run 1: random acks with mid-run overrun and profile rewrite
    rdy_mode = 1;
    push_expected();
    hwrite(8'h00, 32'h1);
    hread(8'h00, v); chk("R3 trigger pending", v, 32'h3);
    @(negedge clk);
    hread(8'h00, v); chk("R3 trigger accepted", v, 32'h0);
    hwrite(8'h00, 32'h1);
    hread(8'h00, v); chk("R7 overrun set", v, 32'h4);
    model[0] = 32'h1234_5678;
    hwrite(8'h04, model[0]);
    hread(8'h04, v); chk("R9 stored during switch", v, model[0]);
    wait_ready();
    chk("R4 queue drained", 32'(expq.size()), 32'd0);
    hread(8'h00, v); chk("R7 overrun kept after switch", v, 32'h6);

    hwrite(8'h00, 32'h0);
    hread(8'h00, v); chk("R8 write 0 keeps overrun", v, 32'h6);
    hwrite(8'h00, 32'h4);
    hread(8'h00, v); chk("R8 write 1 clears overrun", v, 32'h2);

    // Run 2: new profile word, with a long full stall
    rdy_mode = 0;
    push_expected();
    hwrite(8'h00, 32'h1);
    repeat (4) @(negedge clk);
    rdy_mode = 2;
    @(negedge clk);
    sv_valid = dn_valid; sv_addr = dn_addr; sv_data = dn_data; sv_cnt = hs_count;
    repeat (40) @(negedge clk);
    chk("R10 stall valid held", 32'(dn_valid), 32'(sv_valid));
    chk("R10 stall addr held", 32'(dn_addr), 32'(sv_addr));
    chk("R10 stall data held", dn_data, sv_data);
    chk("R10 stall no progress", 32'(hs_count), 32'(sv_cnt));
    rdy_mode = 1;
    wait_ready();
    chk("R4 run2 queue drained", 32'(expq.size()), 32'd0);
    repeat (20) @(negedge clk);
    chk("R7 no stray writes", 32'(hs_count), 32'(NP));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule